// File: doc/BRIEF.md
# Multi-Slave Serial Register Bus Master

This block lets user logic on the fabric side read and write configuration registers in thirteen hardened slave blocks over dedicated serial links. Slave 0 is a MAC-class block with 32-bit registers. Slaves 1 to 12 are SerDes-class blocks with 8-bit registers. Each slave has its own group of eight wires: six driven by the master and two returned by the slave.

A request carries a target index, a write flag, an address, write data and a timeout limit. The request is taken with a valid/ready handshake while the master is idle. The master decodes the target and from it picks the transfer width. It shifts the address, and for writes the data, MSB first onto the selected slave's wires, one bit per clock. It then waits for that slave's acknowledge.

- For a read, the slave returns the data serially after its acknowledge.
- When the transfer ends, the master raises a one-cycle done pulse. On a completed read it also presents the read data.
- If no acknowledge arrives in time, the transfer is aborted and the error flag is raised with done.

The controller states are:

| State | Role | Leaves to |
|---|---|---|
| IDLE | Ready for a request. | ADDR on accept of a valid target; DONE on accept of a bad index. |
| ADDR | Shifts the address bits. | WDATA after the last address bit of a write; WAIT after the last address bit of a read. |
| WDATA | Shifts the write data bits. | WAIT after the last data bit. |
| WAIT | Waits for the selected slave's acknowledge. | DONE when a write is acknowledged; RDATA when a read is acknowledged; DONE on timeout. |
| RDATA | Collects the returned bits. | DONE after the last bit. |
| DONE | Drives the done pulse. | IDLE always. |

Top module: `sbm_master`

## Requirements
- R1: After reset the master is ready, and done, error, read data and every slave-side output are low.
- R2: A request is accepted on a clock edge where valid and ready are both high. Ready is low from the next cycle until the done pulse has passed. Done is high for exactly one cycle and ready returns in the cycle after it.
- R3: Only the addressed slave's select is high during a transaction, and every other slave's outputs stay low. The width wire is high only for target 0 (32-bit mode). The write wire of the selected slave follows the request's write flag.
- R4: A target index of 13 or above causes done with error in the cycle right after the accept. No slave wire is driven and the read data is zero.
- R5: The 8 address bits go out MSB first on the selected slave's serial-out wire, one per cycle, with the strobe wire high. The frame wire is high only on the first address bit.
- R6: A write follows the address with 32 data bits in 32-bit mode, or with the low 8 bits of the write data in 8-bit mode, MSB first, with the strobe wire high.
- R7: After the shift phase the master waits. An acknowledge from the selected slave completes a write, and done follows one cycle later. Acknowledges on other slaves' wires have no effect.
- R8: On a read, the master takes the 32 or 8 bits on the selected slave's serial-in wire, MSB first, in the cycles after the acknowledge. It shows them on rd_data during the done cycle. In 8-bit mode bits 31:8 of rd_data carry the fixed pattern 0x5A5A5A. Serial-in wires of other slaves are ignored.
- R9: With limit L, if no acknowledge arrives within L+1 wait cycles, the transaction ends with done and error. The read data is then zero.
- R10: An acknowledge on the last allowed wait cycle (wait cycle L) completes the transfer without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Master idle, request can be taken |
| req_tgt_i | input | 4 | Target index: 0 is the MAC, 1 to 12 are SerDes |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Register address |
| req_wdata_i | input | 32 | Write data; low byte only in 8-bit mode |
| tmo_limit_i | input | 16 | Acknowledge timeout limit L |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done |
| rd_data_o | output | 32 | Read data, valid with done |
| slv_sel_o | output | 13 | Per-slave select |
| slv_wr_o | output | 13 | Per-slave write flag |
| slv_wide_o | output | 13 | Per-slave 32-bit mode flag |
| slv_frame_o | output | 13 | Per-slave first-bit marker |
| slv_strobe_o | output | 13 | Per-slave bit-valid strobe |
| slv_sdo_o | output | 13 | Per-slave serial data to the slave |
| slv_ack_i | input | 13 | Per-slave acknowledge |
| slv_sdi_i | input | 13 | Per-slave serial data from the slave |

## Verification
Counting from the accept edge:

- The first address bit shows on the slave wires in the next cycle.
- Write data starts right after the 8th address bit.
- The first wait cycle follows the last shifted bit.
- Done rises one cycle after the edge that samples the acknowledge.
- For a read, done rises one cycle after the edge that samples the last returned bit.
- A timeout shows done one cycle after wait cycle L.

The bench drives all inputs and reads all outputs on the falling edge, and walks each transfer one cycle at a time in that order. Every expected value therefore lands in the exact cycle where the registers put it. A check a cycle early or late fails.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_WAIT,
        ST_RDATA,
        ST_DONE
    } sbm_state_e;

endpackage

// File: rtl/sbm_tgt_decode.sv
module sbm_tgt_decode #(
    parameter int NUM_SLV = 13,
    parameter int MAC_IDX = 0,
    parameter int TGT_W   = 4
) (
    input  logic [TGT_W-1:0]   tgt_i,
    output logic               valid_o,
    output logic               wide_o,
    output logic [NUM_SLV-1:0] onehot_o
);

    assign valid_o = (32'(tgt_i) < NUM_SLV);
    assign wide_o  = (32'(tgt_i) == MAC_IDX);

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_sel
        assign onehot_o[g] = (tgt_i == TGT_W'(g));
    end

endmodule

// File: rtl/sbm_shift.sv
module sbm_shift #(
    parameter int ADDR_W   = 8,
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDE_W-1:0] wdata_i,
    input  logic              wide_i,
    input  logic              tx_shift_i,
    input  logic              rx_shift_i,
    input  logic              sdi_i,
    input  logic              cnt_load_i,
    input  logic [CNT_W-1:0]  cnt_val_i,
    output logic              sdo_o,
    output logic              cnt_zero_o,
    output logic [WIDE_W-1:0] rx_o
);

    localparam int TX_W  = ADDR_W + WIDE_W;
    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [TX_W-1:0]   tx_q;
    logic [WIDE_W-1:0] rx_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= wide_i ? {addr_i, wdata_i}
                           : {addr_i, wdata_i[NARROW_W-1:0], {PAD_W{1'b0}}};
        end else if (tx_shift_i) begin
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load_i) begin
            rx_q <= '0;
        end else if (rx_shift_i) begin
            rx_q <= {rx_q[WIDE_W-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load_i) begin
            cnt_q <= cnt_val_i;
        end else if ((tx_shift_i || rx_shift_i) && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign sdo_o      = tx_q[TX_W-1];
    assign cnt_zero_o = (cnt_q == '0);
    assign rx_o       = rx_q;

    // R5/R8: the controller never sends and receives in the same cycle
    a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_shift_i && rx_shift_i));

    // R6: a fresh request is never loaded while a shift is under way
    a_r6_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !(tx_shift_i || rx_shift_i));

endmodule

// File: rtl/sbm_timeout.sv
module sbm_timeout #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    logic [TMO_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the wait count never passes the programmed limit while waiting
    a_r9_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= limit_i));

endmodule

// File: rtl/sbm_master.sv
module sbm_master
    import sbm_pkg::*;
#(
    parameter int                           NUM_SLV  = 13,
    parameter int                           MAC_IDX  = 0,
    parameter int                           ADDR_W   = 8,
    parameter int                           WIDE_W   = 32,
    parameter int                           NARROW_W = 8,
    parameter int                           TMO_W    = 16,
    parameter logic [WIDE_W-NARROW_W-1:0]   FILL_HI  = 24'h5A5A5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [3:0]         req_tgt_i,
    input  logic               req_wr_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [WIDE_W-1:0]  req_wdata_i,
    input  logic [TMO_W-1:0]   tmo_limit_i,
    output logic               done_o,
    output logic               err_o,
    output logic [WIDE_W-1:0]  rd_data_o,
    output logic [NUM_SLV-1:0] slv_sel_o,
    output logic [NUM_SLV-1:0] slv_wr_o,
    output logic [NUM_SLV-1:0] slv_wide_o,
    output logic [NUM_SLV-1:0] slv_frame_o,
    output logic [NUM_SLV-1:0] slv_strobe_o,
    output logic [NUM_SLV-1:0] slv_sdo_o,
    input  logic [NUM_SLV-1:0] slv_ack_i,
    input  logic [NUM_SLV-1:0] slv_sdi_i
);

    localparam int TGT_W = 4;
    localparam int MAXB  = (ADDR_W > WIDE_W) ? ADDR_W : WIDE_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] ADDR_LAST   = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_W - 1);
    localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);

    sbm_state_e state_q, state_d;

    logic [NUM_SLV-1:0] sel_q;
    logic               wr_q, wide_q, err_q, first_q;
    logic [TMO_W-1:0]   tmo_q;

    logic               dec_valid, dec_wide;
    logic [NUM_SLV-1:0] dec_onehot;

    logic               eng_load, tx_shift, rx_shift, cnt_load, cnt_zero, tx_bit;
    logic [CNT_W-1:0]   cnt_val;
    logic [WIDE_W-1:0]  rx_word;
    logic               tmo_clear, tmo_run, tmo_expired;
    logic               ack_sel, sdi_sel, active, accept;

    sbm_tgt_decode #(
        .NUM_SLV (NUM_SLV),
        .MAC_IDX (MAC_IDX),
        .TGT_W   (TGT_W)
    ) u_dec (
        .tgt_i    (req_tgt_i),
        .valid_o  (dec_valid),
        .wide_o   (dec_wide),
        .onehot_o (dec_onehot)
    );

    sbm_shift #(
        .ADDR_W   (ADDR_W),
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W),
        .CNT_W    (CNT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (eng_load),
        .addr_i     (req_addr_i),
        .wdata_i    (req_wdata_i),
        .wide_i     (dec_wide),
        .tx_shift_i (tx_shift),
        .rx_shift_i (rx_shift),
        .sdi_i      (sdi_sel),
        .cnt_load_i (cnt_load),
        .cnt_val_i  (cnt_val),
        .sdo_o      (tx_bit),
        .cnt_zero_o (cnt_zero),
        .rx_o       (rx_word)
    );

    sbm_timeout #(
        .TMO_W (TMO_W)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmo_clear),
        .run_i     (tmo_run),
        .limit_i   (tmo_q),
        .expired_o (tmo_expired)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid_i;
    assign ack_sel = |(slv_ack_i & sel_q);
    assign sdi_sel = |(slv_sdi_i & sel_q);

    // next-state and datapath control
    always_comb begin
        state_d   = state_q;
        eng_load  = 1'b0;
        tx_shift  = 1'b0;
        rx_shift  = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        tmo_clear = 1'b0;
        tmo_run   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (dec_valid) begin
                        state_d  = ST_ADDR;
                        eng_load = 1'b1;
                        cnt_load = 1'b1;
                        cnt_val  = ADDR_LAST;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_ADDR: begin
                tx_shift = 1'b1;
                if (cnt_zero) begin
                    if (wr_q) begin
                        state_d  = ST_WDATA;
                        cnt_load = 1'b1;
                        cnt_val  = wide_q ? WIDE_LAST : NARROW_LAST;
                    end else begin
                        state_d   = ST_WAIT;
                        tmo_clear = 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                tx_shift = 1'b1;
                if (cnt_zero) begin
                    state_d   = ST_WAIT;
                    tmo_clear = 1'b1;
                end
            end
            ST_WAIT: begin
                tmo_run = 1'b1;
                if (ack_sel) begin
                    if (wr_q) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_RDATA;
                        cnt_load = 1'b1;
                        cnt_val  = wide_q ? WIDE_LAST : NARROW_LAST;
                    end
                end else if (tmo_expired) begin
                    state_d = ST_DONE;
                end
            end
            ST_RDATA: begin
                rx_shift = 1'b1;
                if (cnt_zero) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            err_q   <= 1'b0;
            first_q <= 1'b0;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                sel_q   <= dec_onehot;
                wr_q    <= req_wr_i;
                wide_q  <= dec_wide;
                err_q   <= !dec_valid;
                first_q <= 1'b1;
                tmo_q   <= tmo_limit_i;
            end else begin
                if (state_q == ST_ADDR) begin
                    first_q <= 1'b0;
                end
                if (state_q == ST_WAIT && !ack_sel && tmo_expired) begin
                    err_q <= 1'b1;
                end
                if (state_q == ST_DONE) begin
                    sel_q <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        active = (state_q == ST_ADDR) || (state_q == ST_WDATA) ||
                 (state_q == ST_WAIT) || (state_q == ST_RDATA);
        req_ready_o = (state_q == ST_IDLE);
        done_o      = (state_q == ST_DONE);
        err_o       = done_o && err_q;
        rd_data_o   = '0;
        if (done_o && !wr_q && !err_q) begin
            rd_data_o = wide_q ? rx_word : {FILL_HI, rx_word[NARROW_W-1:0]};
        end
    end

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_port
        logic shifting;
        assign shifting        = (state_q == ST_ADDR) || (state_q == ST_WDATA);
        assign slv_sel_o[g]    = active && sel_q[g];
        assign slv_wr_o[g]     = active && sel_q[g] && wr_q;
        assign slv_wide_o[g]   = active && sel_q[g] && wide_q;
        assign slv_frame_o[g]  = sel_q[g] && (state_q == ST_ADDR) && first_q;
        assign slv_strobe_o[g] = sel_q[g] && shifting;
        assign slv_sdo_o[g]    = sel_q[g] && shifting && tx_bit;
    end

    // R3: at most one slave is selected
    a_r3_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_sel_o));

    // R3: an idle master leaves every slave wire quiet
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (slv_sel_o == '0 && slv_strobe_o == '0 && slv_sdo_o == '0));

    // R2: done lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: an accepted request makes the master busy
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R4: an out-of-range index ends at once with an error
    a_r4_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && (32'(req_tgt_i) >= NUM_SLV))
            |=> (done_o && err_o && slv_sel_o == '0));

endmodule

// File: tb/test_sbm_master.sv
module test_sbm_master;

    localparam int NS = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic          req_ready_o;
    logic [3:0]    req_tgt_i = '0;
    logic          req_wr_i = 1'b0;
    logic [7:0]    req_addr_i = '0;
    logic [31:0]   req_wdata_i = '0;
    logic [15:0]   tmo_limit_i = '0;
    logic          done_o, err_o;
    logic [31:0]   rd_data_o;
    logic [NS-1:0] slv_sel_o, slv_wr_o, slv_wide_o, slv_frame_o, slv_strobe_o, slv_sdo_o;
    logic [NS-1:0] slv_ack_i = '0;
    logic [NS-1:0] slv_sdi_i = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sbm_master i_sbm_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_tgt_i    (req_tgt_i),
        .req_wr_i     (req_wr_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .tmo_limit_i  (tmo_limit_i),
        .done_o       (done_o),
        .err_o        (err_o),
        .rd_data_o    (rd_data_o),
        .slv_sel_o    (slv_sel_o),
        .slv_wr_o     (slv_wr_o),
        .slv_wide_o   (slv_wide_o),
        .slv_frame_o  (slv_frame_o),
        .slv_strobe_o (slv_strobe_o),
        .slv_sdo_o    (slv_sdo_o),
        .slv_ack_i    (slv_ack_i),
        .slv_sdi_i    (slv_sdi_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 64'(req_ready_o), 64'd1);
        chk("R1", "done/err/rd_data after reset", {31'd0, done_o, err_o, rd_data_o}, 64'd0);
        chk("R1", "slave wires after reset",
            64'({slv_sel_o, slv_wr_o, slv_wide_o, slv_frame_o, slv_strobe_o, slv_sdo_o}), 64'd0);
    endtask

    // one complete transfer; ack_at larger than tmo means no acknowledge
    task automatic t_txn(input string tag, input int tgt, input bit wr,
                         input logic [7:0] addr, input logic [31:0] wdata,
                         input logic [31:0] rdata, input int ack_at, input int tmo);
        bit               wide = (tgt == 0);
        int               dw = wide ? 32 : 8;
        int               other = (tgt + 1) % NS;
        logic [NS-1:0]    oh = NS'(1) << tgt;
        logic [7:0]       got_a = '0;
        logic [31:0]      got_d = '0;
        logic [31:0]      exp_rd;
        bit               wires_ok = 1'b1;
        bit               frame_ok = 1'b1;
        bit               acked = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b1; req_tgt_i = 4'(tgt); req_wr_i = wr;
        req_addr_i = addr; req_wdata_i = wdata; tmo_limit_i = 16'(tmo);
        @(negedge clk);
        req_valid_i = 1'b0; req_addr_i = ~addr; req_wdata_i = ~wdata; tmo_limit_i = '0;
        chk({tag, " R2"}, "ready while busy", 64'(req_ready_o), 64'd0);
        for (int i = 0; i < 8; i++) begin
            wires_ok &= (slv_sel_o == oh) && (slv_strobe_o == oh) &&
                        (slv_wr_o == (wr ? oh : '0)) && (slv_wide_o == (wide ? oh : '0));
            frame_ok &= (slv_frame_o == ((i == 0) ? oh : '0));
            got_a = {got_a[6:0], slv_sdo_o[tgt]};
            @(negedge clk);
        end
        chk({tag, " R5"}, "address bits", 64'(got_a), 64'(addr));
        chk({tag, " R5"}, "frame on first bit only", 64'(frame_ok), 64'd1);
        if (wr) begin
            for (int i = 0; i < dw; i++) begin
                wires_ok &= (slv_sel_o == oh) && (slv_strobe_o == oh) && (slv_frame_o == '0);
                got_d = {got_d[30:0], slv_sdo_o[tgt]};
                @(negedge clk);
            end
            chk({tag, " R6"}, "write data bits", 64'(got_d),
                64'(wide ? wdata : {24'd0, wdata[7:0]}));
        end
        for (int w = 0; w <= tmo; w++) begin
            wires_ok &= (slv_sel_o == oh) && (slv_strobe_o == '0) && !done_o;
            if (w == ack_at) begin
                slv_ack_i[tgt] = 1'b1;
                @(negedge clk);
                slv_ack_i = '0;
                acked = 1'b1;
                break;
            end
            slv_ack_i[other] = 1'b1; // R7: foreign acknowledge must be ignored
            @(negedge clk);
            slv_ack_i = '0;
        end
        if (acked && !wr) begin
            for (int i = 0; i < dw; i++) begin
                wires_ok &= (slv_sel_o == oh) && !done_o;
                slv_sdi_i = {NS{~rdata[dw-1-i]}}; // R8: other slaves drive noise
                slv_sdi_i[tgt] = rdata[dw-1-i];
                @(negedge clk);
            end
            slv_sdi_i = '0;
        end
        exp_rd = (acked && !wr) ? (wide ? rdata : {24'h5A5A5A, rdata[7:0]}) : 32'd0;
        chk({tag, " R3"}, "only target wires driven, width/write flags", 64'(wires_ok), 64'd1);
        chk({tag, " R7"}, "done after shift/ack", 64'(done_o), 64'd1);
        chk({tag, " R9"}, "error flag", 64'(err_o), 64'(!acked));
        chk({tag, " R8"}, "read data", 64'(rd_data_o), 64'(exp_rd));
        @(negedge clk);
        chk({tag, " R2"}, "done pulse ended, ready back",
            64'({done_o, req_ready_o, |slv_sel_o}), 64'b010);
    endtask

    task automatic t_bad_index(input int tgt);
        @(negedge clk);
        req_valid_i = 1'b1; req_tgt_i = 4'(tgt); req_wr_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R4", "done+err on bad index", 64'({done_o, err_o}), 64'b11);
        chk("R4", "no slave wire, zero data",
            64'({|slv_sel_o, |slv_strobe_o, rd_data_o}), 64'd0);
        @(negedge clk);
        chk("R4", "ready after bad index", 64'({req_ready_o, done_o}), 64'b10);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_txn("mac write",     0,  1'b1, 8'hC5, 32'h8123_4567, 32'h0, 3, 10);
        t_txn("serdes write",  5,  1'b1, 8'h3A, 32'hFFFF_FF96, 32'h0, 0, 10);
        t_txn("mac read",      0,  1'b0, 8'h81, 32'h0, 32'hDEAD_BEEF, 2, 10);
        t_txn("serdes read",   12, 1'b0, 8'h7E, 32'h0, 32'h1234_56C3, 1, 10);
        t_txn("timeout R9",    7,  1'b0, 8'h55, 32'h0, 32'hFFFF_FFFF, 99, 4);
        t_txn("last ack R10",  3,  1'b1, 8'hA0, 32'h0000_0069, 32'h0, 4, 4);
        t_txn("late read R10", 9,  1'b0, 8'h0F, 32'h0, 32'h0000_00B4, 2, 2);
        t_bad_index(13);
        t_bad_index(15);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule